// File: doc/BRIEF.md
# Parity Bus Transceiver with Latched Error Flag

This block passes an 8-bit word between two bus sides, A and B, in either direction, and attaches a ninth bit so that the word has odd parity. Two active-low direction controls choose the path. When the B side is driven from A, the block generates the parity bit and drives it out. When the A side is driven from B, the parity line is an input and the block checks the nine received bits. With both controls asserted, the block still drives B from A, but the generated parity is inverted. This lets a system inject a deliberate parity fault. With both controls released, nothing is driven.

Each tri-state pin is split into a data-in, a data-out and an output-enable signal. A parity check node is high when the checked 9-bit word is good. A clocked flag register samples this node under the control of an active-low flag enable and an active-low flag clear. This gives four modes:
- follow the node every cycle;
- sticky accumulate, where the flag falls on an error and stays low;
- force to no-error;
- hold.

The flag output is active-low and comes with an enable that models an open-collector pull-down.

Top module: `parity_xcvr`

## Requirements
- R1: With `a_drive_n`=1 and `b_drive_n`=0, `b_out` equals `a_in` and `b_oe`=1, `a_oe`=0 and `par_oe`=1. `par_out` is 1 when `a_in` holds an even number of ones and 0 when it holds an odd number.
- R2: With `a_drive_n`=0 and `b_drive_n`=1, `a_out` equals `b_in` and `a_oe`=1, `b_oe`=0 and `par_oe`=0. The parity line is then taken from `par_in`.
- R3: With both direction controls at 0, `b_out` equals `a_in`, `b_oe`=1, `a_oe`=0 and `par_oe`=1. `par_out` is 0 for an even count of ones on `a_in` and 1 for an odd count.
- R4: With both direction controls at 1, `a_oe`, `b_oe` and `par_oe` are all 0.
- R5: With `flag_en_n`=0 and `flag_clr_n`=0 (follow mode), `err_n` after each rising clock edge equals the check node from before that edge. In the B-to-A direction the check node is 1 when `b_in` together with `par_in` holds an odd number of ones.
- R6: With `flag_en_n`=0 and `flag_clr_n`=1 (sticky mode), `err_n` after the edge is the check node ANDed with the previous `err_n`. Once it is 0 it stays 0 while this mode lasts.
- R7: With `flag_en_n`=1 and `flag_clr_n`=0, `err_n` becomes 1 at the next rising edge.
- R8: With `flag_en_n`=1 and `flag_clr_n`=1, `err_n` keeps its value whatever the buses carry.
- R9: With both direction controls at 1, the check node is 1 when `a_in` has an odd count of ones and 0 when it has an even count.
- R10: In the A-to-B direction the check node covers `a_in` plus the generated parity. It is 1 in the normal mode of R1 and 0 in the inverted mode of R3.
- R11: While `rst_n`=0, `err_n`=1 regardless of the clock. At all times `err_oe` is 1 exactly when `err_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flag register clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, sets flag to no-error |
| a_drive_n | input | 1 | Active-low: drive the A side from B |
| b_drive_n | input | 1 | Active-low: drive the B side from A |
| a_in | input | 8 | A side pad input |
| a_out | output | 8 | A side pad output data |
| a_oe | output | 1 | A side pad output enable |
| b_in | input | 8 | B side pad input |
| b_out | output | 8 | B side pad output data |
| b_oe | output | 1 | B side pad output enable |
| par_in | input | 1 | Parity pad input |
| par_out | output | 1 | Parity pad output data |
| par_oe | output | 1 | Parity pad output enable |
| flag_en_n | input | 1 | Active-low flag update enable |
| flag_clr_n | input | 1 | Active-low flag clear / mode select |
| err_n | output | 1 | Latched error flag, low means parity error |
| err_oe | output | 1 | Pull-down enable for the error pad |

## Verification
The hardest case to reach is the sticky mode staying low after a good word. It needs a sequence: clear the flag, accumulate once on a good word, once on a bad word, then present good words again. The stimulus builds that sequence, then switches to hold with new bus values to confirm that nothing leaks in. The inverted-parity mode is also driven in follow mode, which shows that the check node drops to zero without any received word.

// File: rtl/parity_xcvr.sv
module parity_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_drive_n,
  input  logic         b_drive_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         par_in,
  output logic         par_out,
  output logic         par_oe,
  input  logic         flag_en_n,
  input  logic         flag_clr_n,
  output logic         err_n,
  output logic         err_oe
);

  logic inv_mode;
  logic chk;
  logic flag_q;

  assign inv_mode = ~a_drive_n & ~b_drive_n;

  assign b_out   = a_in;
  assign b_oe    = ~b_drive_n;
  assign a_out   = b_in;
  assign a_oe    = ~a_drive_n & b_drive_n;
  assign par_oe  = ~b_drive_n;
  assign par_out = ~(^a_in) ^ inv_mode;

  always_comb begin
    case ({a_drive_n, b_drive_n})
      2'b01:   chk = ^{b_in, par_in};
      2'b11:   chk = ^a_in;
      default: chk = ^{a_in, par_out};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b1;
    end else begin
      case ({flag_en_n, flag_clr_n})
        2'b00:   flag_q <= chk;
        2'b01:   flag_q <= chk & flag_q;
        2'b10:   flag_q <= 1'b1;
        default: flag_q <= flag_q;
      endcase
    end
  end

  assign err_n  = flag_q;
  assign err_oe = ~flag_q;

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en_n && !flag_clr_n) |=> err_n);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_en_n && flag_clr_n && !err_n) |=> !err_n);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en_n && flag_clr_n) |=> $stable(err_n));

  assert_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_en_n && !flag_clr_n && !a_drive_n && b_drive_n) |=> (err_n == $past(^{b_in, par_in})));

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_drive_n && b_drive_n) |-> !(a_oe || b_oe || par_oe));

endmodule

// File: tb/test_parity_xcvr.sv
module test_parity_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       a_drive_n, b_drive_n;
  logic [7:0] a_in, b_in;
  logic       par_in, flag_en_n, flag_clr_n;
  logic [7:0] a_out, b_out;
  logic       a_oe, b_oe, par_out, par_oe, err_n, err_oe;

  int checks   = 0;
  int failures = 0;
  logic err_m;
  bit   done = 1'b0;

  typedef struct {
    string      req;
    logic [21:0] exp;
    logic [21:0] mask;
  } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  parity_xcvr i_parity_xcvr (
    .clk(clk), .rst_n(rst_n), .a_drive_n(a_drive_n), .b_drive_n(b_drive_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
    .flag_en_n(flag_en_n), .flag_clr_n(flag_clr_n), .err_n(err_n), .err_oe(err_oe)
  );

  function automatic logic [21:0] pack_outs();
    return {a_oe, a_out, b_oe, b_out, par_oe, par_out, err_n, err_oe};
  endfunction

  task automatic step(input logic ad, input logic bd, input logic [7:0] a, input logic [7:0] b,
                      input logic p, input logic en, input logic clr, input string req);
    item_t it;
    logic e_aoe, e_boe, e_poe, e_par, node;
    @(negedge clk);
    a_drive_n = ad; b_drive_n = bd; a_in = a; b_in = b; par_in = p;
    flag_en_n = en; flag_clr_n = clr;
    e_boe = !bd;
    e_aoe = !ad && bd;
    e_poe = !bd;
    e_par = (!ad && !bd) ? (^a) : !(^a);
    if (!ad && bd)      node = ^{b, p};
    else if (ad && bd)  node = ^a;
    else if (!ad && !bd) node = 1'b0;
    else                node = 1'b1;
    case ({en, clr})
      2'b00:   err_m = node;
      2'b01:   err_m = node & err_m;
      2'b10:   err_m = 1'b1;
      default: err_m = err_m;
    endcase
    it.req  = req;
    it.exp  = {e_aoe, b, e_boe, a, e_poe, e_par, err_m, !err_m};
    it.mask = {1'b1, {8{e_aoe}}, 1'b1, {8{e_boe}}, 1'b1, e_poe, 1'b1, 1'b1};
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (q.size() > 0) begin
      item_t it;
      logic [21:0] act;
      it  = q.pop_front();
      act = pack_outs();
      checks++;
      if ((act & it.mask) !== (it.exp & it.mask)) begin
        failures++;
        $display("FAIL %s actual=%06h expected=%06h mask=%06h", it.req, act, it.exp, it.mask);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; a_drive_n = 1'b1; b_drive_n = 1'b1; a_in = 8'h00; b_in = 8'h00;
    par_in = 1'b0; flag_en_n = 1'b1; flag_clr_n = 1'b1;
    err_m = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (err_n !== 1'b1 || err_oe !== 1'b0) begin
      failures++;
      $display("FAIL R11 reset actual=%b%b expected=10", err_n, err_oe);
    end
    rst_n = 1'b1;

    step(1, 0, 8'h00, 8'h3C, 0, 0, 0, "R1 R10 even A");
    step(1, 0, 8'h07, 8'h00, 1, 0, 0, "R1 odd A");
    for (int i = 0; i < 4; i++)
      step(1, 0, 8'h11 << i | 8'h80 >> i, 8'h55, 0, 0, 0, "R1 pattern");
    step(0, 0, 8'h03, 8'hFF, 0, 0, 0, "R3 R10 inverted even");
    step(0, 0, 8'h01, 8'hFF, 0, 1, 1, "R3 inverted odd hold");
    step(1, 1, 8'h00, 8'h00, 0, 1, 0, "R7 clear");
    step(0, 1, 8'h00, 8'hA5, 1, 0, 0, "R2 R5 good word");
    step(0, 1, 8'h00, 8'hA5, 0, 0, 0, "R5 bad word");
    step(0, 1, 8'h00, 8'h5A, 1, 1, 1, "R8 hold low");
    for (int i = 0; i < 3; i++)
      step(0, 1, 8'hC3, 8'h01 << i, 0, 0, 0, "R2 R5 pattern");
    step(0, 1, 8'h00, 8'h00, 1, 1, 0, "R7 clear again");
    step(0, 1, 8'h00, 8'hF0, 1, 0, 1, "R6 sticky good");
    step(0, 1, 8'h00, 8'hF0, 0, 0, 1, "R6 sticky bad");
    step(0, 1, 8'h00, 8'hF1, 0, 0, 1, "R6 sticky stays low");
    step(1, 1, 8'h01, 8'h00, 0, 1, 1, "R8 hold after sticky");
    step(1, 1, 8'h00, 8'h00, 0, 1, 0, "R7 clear third");
    step(1, 1, 8'h01, 8'h77, 1, 0, 0, "R4 R9 odd A");
    step(1, 1, 8'h81, 8'h77, 1, 0, 0, "R4 R9 even A");
    step(1, 1, 8'hFE, 8'h00, 0, 0, 0, "R4 R9 odd A again");
    step(0, 1, 8'h00, 8'h00, 0, 1, 1, "R8 hold ignores bad word");
    step(0, 0, 8'hAA, 8'h00, 0, 0, 1, "R10 sticky inverted");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    checks++;
    if (err_n !== 1'b1 || err_oe !== 1'b0) begin
      failures++;
      $display("FAIL R11 async reset actual=%b%b expected=10", err_n, err_oe);
    end
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule